// File: doc/BRIEF.md
# Tamper Pin Event Filter

This block monitors a single external tamper pin and latches a tamper flag when the pin shows a qualifying event. It brings the pin into the clock domain through a synchroniser, then applies one of two detection schemes chosen by a 2-bit filter code. With the filter code at zero, a single edge of the chosen direction is enough. With a non-zero code, the pin is sampled periodically, and 2, 4 or 8 consecutive samples at the active level are needed.

In filtered mode, a prescaler derives the sample period from the clock, which is the real-time-counter clock. A pull-up strobe can be driven for a short programmable precharge window that ends on each sample cycle. A detected event sets a sticky flag. The flag is mirrored to an interrupt request when interrupts are enabled. It also produces a one-cycle timestamp-capture pulse when that option is on. Software clears the flag with a clear strobe.

Top module: `tamper_filter`

## Requirements
- R1: With filter code 0 and the block enabled, polarity 0 selects rising edges and polarity 1 selects falling edges. The flag becomes 1 on the third rising clock edge after the pin changes: two edges pass through the synchroniser and one edge is the flag register.
- R2: With filter code 0, an edge opposite to the selected polarity leaves the flag unchanged.
- R3: With a non-zero filter code, the pin is sampled once every 32768 >> rate clock cycles, where rate is 0 to 7. The sample period is counted from the cycle after enable goes high. Samples are taken on cycles P, 2P, 3P and so on.
- R4: Filter codes 1, 2 and 3 need 2, 4 and 8 consecutive active samples before an event is declared. Polarity 0 means a low level is active and polarity 1 means a high level is active. An inactive sample restarts the count.
- R5: In filtered mode with the pull-up enabled, the pull-up strobe is high for 1, 2, 4 or 8 cycles (precharge code 0 to 3). These cycles end on the sample cycle. The strobe is never driven in unfiltered mode.
- R6: With the pull-up disabled, the pull-up strobe stays low and there is no precharge phase.
- R7: The flag resets to 0 and stays set until a clear strobe is applied. The clear takes effect on the next clock edge. If an event and a clear arrive in the same cycle, the flag remains set.
- R8: The interrupt request equals the flag gated by the interrupt enable, and it is registered on the same edge as the flag.
- R9: When timestamp capture is enabled, each detected event produces exactly one single-cycle capture pulse. When it is disabled, no pulse is produced.
- R10: While enable is 0, no event is detected, and the prescaler and the consecutive-sample counter are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time-counter clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous tamper pin |
| cfg_enable | input | 1 | Detection enable |
| cfg_polarity | input | 1 | Edge direction or active level |
| cfg_rate | input | 3 | Sample period code (32768 >> code cycles) |
| cfg_filter | input | 2 | 0 selects edge mode; 1/2/3 select 2/4/8 samples |
| cfg_prech | input | 2 | Precharge length code (1/2/4/8 cycles) |
| cfg_pullup_en | input | 1 | Pull-up precharge enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_ts_en | input | 1 | Timestamp-capture request enable |
| flag_clr | input | 1 | Flag clear strobe |
| tamper_flag | output | 1 | Sticky tamper flag |
| tamper_irq | output | 1 | Interrupt request |
| ts_capture | output | 1 | One-cycle timestamp-capture pulse |
| pullup_drv | output | 1 | Pull-up precharge strobe |

## Verification
A prescaler that starts from the wrong value, or that is not cleared when enable drops, moves the flag's rising edge by whole sample periods. A stale consecutive-sample count makes the flag rise one or more periods early. Both faults are therefore caught by checking the exact cycle at which the flag rises, one cycle before and on the expected edge. An off-by-one precharge threshold shows up as a wrong count of pull-up strobe cycles within two sample periods. A repeated or missing event shows up as an extra or absent capture pulse at the scoreboard.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned RATE_W = 3;
  localparam int unsigned FILT_W = 2;
  localparam int unsigned PRE_W  = 2;

  typedef enum logic [FILT_W-1:0] {
    FILT_OFF = 2'd0,
    FILT_2   = 2'd1,
    FILT_4   = 2'd2,
    FILT_8   = 2'd3
  } filt_e;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tamper_presc.sv
module tamper_presc #(
  parameter int unsigned CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] rate,
  input  logic [1:0] prech,
  input  logic       pullup_en,
  output logic       samp_stb,
  output logic       pullup_q
);
  logic [CNT_W-1:0] cnt, nxt, term, len, thr;

  always_comb begin
    term     = {CNT_W{1'b1}} >> rate;
    len      = CNT_W'(1) << prech;
    thr      = term - len + CNT_W'(1);
    samp_stb = run && (cnt == term);
    if (!run)            nxt = '0;
    else if (cnt == term) nxt = '0;
    else                 nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      pullup_q <= 1'b0;
    end else begin
      cnt      <= nxt;
      pullup_q <= run && pullup_en && (nxt >= thr);
    end
  end
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamper_pkg::*;
#(
  parameter int unsigned RUN_W = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  filt_e filt,
  input  logic  pol,
  input  logic  pin_s,
  input  logic  stb,
  output logic  evt
);
  logic             pin_d;
  logic [RUN_W-1:0] run, need;
  logic             active, edge_hit, lvl_hit;

  always_comb begin
    need     = RUN_W'(1) << filt;
    active   = (pin_s == pol);
    edge_hit = pol ? (pin_d & ~pin_s) : (pin_s & ~pin_d);
    lvl_hit  = stb && active && (run == need - RUN_W'(1));
    evt      = en && ((filt == FILT_OFF) ? edge_hit : lvl_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || filt == FILT_OFF) begin
      run <= '0;
    end else if (stb) begin
      if (!active)          run <= '0;
      else if (run >= need) run <= need;
      else                  run <= run + RUN_W'(1);
    end
  end
endmodule

// File: rtl/tamper_filter.sv
module tamper_filter
  import tamper_pkg::*;
#(
  parameter int unsigned CNT_W       = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       cfg_enable,
  input  logic       cfg_polarity,
  input  logic [2:0] cfg_rate,
  input  logic [1:0] cfg_filter,
  input  logic [1:0] cfg_prech,
  input  logic       cfg_pullup_en,
  input  logic       cfg_irq_en,
  input  logic       cfg_ts_en,
  input  logic       flag_clr,
  output logic       tamper_flag,
  output logic       tamper_irq,
  output logic       ts_capture,
  output logic       pullup_drv
);
  localparam int unsigned RUN_W = 4;

  filt_e filt;
  logic  pin_s, stb, evt, presc_run, flag_nxt;

  assign filt      = filt_e'(cfg_filter);
  assign presc_run = cfg_enable && (filt != FILT_OFF);

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  tamper_presc #(.CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst(rst), .run(presc_run), .rate(cfg_rate),
    .prech(cfg_prech), .pullup_en(cfg_pullup_en),
    .samp_stb(stb), .pullup_q(pullup_drv)
  );

  tamper_detect #(.RUN_W(RUN_W)) u_det (
    .clk(clk), .rst(rst), .en(cfg_enable), .filt(filt),
    .pol(cfg_polarity), .pin_s(pin_s), .stb(stb), .evt(evt)
  );

  assign flag_nxt = evt | (tamper_flag & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      tamper_flag <= 1'b0;
      tamper_irq  <= 1'b0;
      ts_capture  <= 1'b0;
    end else begin
      tamper_flag <= flag_nxt;
      tamper_irq  <= flag_nxt & cfg_irq_en;
      ts_capture  <= evt & cfg_ts_en;
    end
  end
endmodule

// File: rtl/tamper_filter_chk.sv
module tamper_filter_chk (
  input logic clk,
  input logic rst,
  input logic cfg_enable,
  input logic cfg_pullup_en,
  input logic cfg_ts_en,
  input logic flag_clr,
  input logic tamper_flag,
  input logic tamper_irq,
  input logic ts_capture,
  input logic pullup_drv
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tamper_flag && !flag_clr) |=> tamper_flag); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    tamper_irq |-> tamper_flag); // R8
  AST_TS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ts_capture |-> ($past(cfg_ts_en) && tamper_flag)); // R9
  AST_TS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ts_capture |=> !ts_capture); // R9
  AST_PULLUP_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg_pullup_en |=> !pullup_drv); // R6
  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(tamper_flag) |-> $past(cfg_enable)); // R10
  AST_IDLE_NO_PULLUP: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !pullup_drv); // R10
endmodule

bind tamper_filter tamper_filter_chk u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable),
  .cfg_pullup_en(cfg_pullup_en), .cfg_ts_en(cfg_ts_en),
  .flag_clr(flag_clr), .tamper_flag(tamper_flag),
  .tamper_irq(tamper_irq), .ts_capture(ts_capture),
  .pullup_drv(pullup_drv)
);

// File: tb/tb_tamper_filter.sv
`timescale 1ns/1ps
module tb_tamper_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_in = 1'b0;
  logic cfg_enable = 1'b0, cfg_polarity = 1'b0;
  logic [2:0] cfg_rate = 3'd7;
  logic [1:0] cfg_filter = 2'd0, cfg_prech = 2'd0;
  logic cfg_pullup_en = 1'b0, cfg_irq_en = 1'b0, cfg_ts_en = 1'b0;
  logic flag_clr = 1'b0;
  logic tamper_flag, tamper_irq, ts_capture, pullup_drv;

  int checks = 0;
  int errors = 0;
  int cur_id = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tamper_filter dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_enable(cfg_enable),
    .cfg_polarity(cfg_polarity), .cfg_rate(cfg_rate), .cfg_filter(cfg_filter),
    .cfg_prech(cfg_prech), .cfg_pullup_en(cfg_pullup_en), .cfg_irq_en(cfg_irq_en),
    .cfg_ts_en(cfg_ts_en), .flag_clr(flag_clr), .tamper_flag(tamper_flag),
    .tamper_irq(tamper_irq), .ts_capture(ts_capture), .pullup_drv(pullup_drv)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ts(input int id);
    cur_id = id;
    exp_q.push_back(id);
  endtask

  task automatic count_pu(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      edges(1);
      if (pullup_drv) cnt++;
    end
  endtask

  task automatic reset_cfg();
    cfg_enable = 1'b0; cfg_irq_en = 1'b0; cfg_ts_en = 1'b0;
    cfg_pullup_en = 1'b0; cfg_filter = 2'd0; cfg_prech = 2'd0;
    cfg_rate = 3'd7; cfg_polarity = 1'b0;
    flag_clr = 1'b1;
    edges(1);
    flag_clr = 1'b0;
    edges(2);
  endtask

  // scoreboard monitor: every capture pulse must match a queued expectation
  always @(negedge clk) begin
    if (!rst && ts_capture) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 actual=unexpected capture pulse expected=none (scenario %0d)", cur_id);
      end else begin
        int id;
        id = exp_q.pop_front();
        if (id != cur_id) begin
          errors++;
          $display("FAIL R9 actual=scenario %0d expected=scenario %0d", cur_id, id);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    edges(3);
    rst = 1'b0;
    edges(1);
    // R7 reset state
    chk("R7 reset flag", tamper_flag, 0);
    chk("R8 reset irq", tamper_irq, 0);
    chk("R9 reset ts", ts_capture, 0);
    chk("R5 reset pullup", pullup_drv, 0);

    // R1 rising edge, unfiltered
    cfg_enable = 1'b1; cfg_irq_en = 1'b1; cfg_ts_en = 1'b1;
    edges(2);
    expect_ts(1);
    pin_in = 1'b1;
    edges(2);
    chk("R1 flag before 3rd edge", tamper_flag, 0);
    edges(1);
    chk("R1 flag on 3rd edge", tamper_flag, 1);
    chk("R8 irq follows flag", tamper_irq, 1);

    // R2 opposite edge ignored
    flag_clr = 1'b1; edges(1); flag_clr = 1'b0;
    pin_in = 1'b0;
    edges(6);
    chk("R2 falling ignored with polarity 0", tamper_flag, 0);

    // R1 falling edge with polarity 1
    cfg_polarity = 1'b1;
    edges(2);
    pin_in = 1'b1;
    edges(5);
    chk("R2 rising ignored with polarity 1", tamper_flag, 0);
    expect_ts(2);
    pin_in = 1'b0;
    edges(2);
    chk("R1 falling before 3rd edge", tamper_flag, 0);
    edges(1);
    chk("R1 falling on 3rd edge", tamper_flag, 1);

    // R7 event wins over clear
    pin_in = 1'b1;
    edges(5);
    expect_ts(3);
    pin_in = 1'b0;
    edges(2);
    flag_clr = 1'b1;
    edges(1);
    flag_clr = 1'b0;
    chk("R7 event beats clear", tamper_flag, 1);
    flag_clr = 1'b1; edges(1); flag_clr = 1'b0;
    chk("R7 clear alone", tamper_flag, 0);
    chk("R8 irq drops with flag", tamper_irq, 0);

    // R8 irq gating, R9 capture disabled
    cfg_irq_en = 1'b0; cfg_ts_en = 1'b0; cfg_polarity = 1'b0;
    edges(2);
    pin_in = 1'b1;
    edges(3);
    chk("R8 flag set with irq off", tamper_flag, 1);
    chk("R8 irq masked", tamper_irq, 0);
    cfg_irq_en = 1'b1;
    edges(1);
    chk("R8 irq after enabling", tamper_irq, 1);

    // R10 disabled: edges ignored
    reset_cfg();
    pin_in = 1'b0;
    edges(4);
    pin_in = 1'b1;
    edges(5);
    chk("R10 edge ignored while disabled", tamper_flag, 0);

    // R3 R4 filtered, 2 samples, high level, period 256
    reset_cfg();
    pin_in = 1'b1; cfg_polarity = 1'b1; cfg_filter = 2'd1; cfg_rate = 3'd7;
    cfg_pullup_en = 1'b1; cfg_ts_en = 1'b1;
    edges(4);
    expect_ts(4);
    cfg_enable = 1'b1;
    edges(511);
    chk("R3 no event before 2nd sample", tamper_flag, 0);
    edges(1);
    chk("R4 event on 2nd active sample", tamper_flag, 1);

    // R5 R6 R3 pull-up strobe counts
    reset_cfg();
    pin_in = 1'b0; cfg_polarity = 1'b1; cfg_filter = 2'd1; cfg_pullup_en = 1'b1;
    edges(4);
    cfg_enable = 1'b1;
    count_pu(512, n);
    chk("R5 precharge 1 cycle x2 samples", n, 2);
    reset_cfg();
    cfg_polarity = 1'b1; cfg_filter = 2'd1; cfg_pullup_en = 1'b1; cfg_prech = 2'd3;
    edges(4);
    cfg_enable = 1'b1;
    count_pu(512, n);
    chk("R5 precharge 8 cycles x2 samples", n, 16);
    reset_cfg();
    cfg_polarity = 1'b1; cfg_filter = 2'd1; cfg_pullup_en = 1'b0; cfg_prech = 2'd3;
    edges(4);
    cfg_enable = 1'b1;
    count_pu(512, n);
    chk("R6 pull-up disabled", n, 0);
    reset_cfg();
    cfg_polarity = 1'b1; cfg_filter = 2'd1; cfg_pullup_en = 1'b1; cfg_rate = 3'd6;
    edges(4);
    cfg_enable = 1'b1;
    count_pu(512, n);
    chk("R3 period 512 gives one sample", n, 1);
    reset_cfg();
    cfg_filter = 2'd0; cfg_pullup_en = 1'b1; cfg_prech = 2'd3;
    edges(4);
    cfg_enable = 1'b1;
    count_pu(256, n);
    chk("R5 no pull-up in edge mode", n, 0);

    // R10 disabling clears run count and prescaler
    reset_cfg();
    pin_in = 1'b1; cfg_polarity = 1'b1; cfg_filter = 2'd1; cfg_pullup_en = 1'b1;
    edges(4);
    cfg_enable = 1'b1;
    edges(300);
    cfg_enable = 1'b0;
    edges(3);
    cfg_enable = 1'b1;
    edges(511);
    chk("R10 count restarted after disable", tamper_flag, 0);
    edges(1);
    chk("R10 event after fresh 2 samples", tamper_flag, 1);

    // R4 inactive sample restarts count (4 samples)
    reset_cfg();
    pin_in = 1'b1; cfg_polarity = 1'b1; cfg_filter = 2'd2;
    edges(4);
    cfg_enable = 1'b1;
    edges(300);
    pin_in = 1'b0;
    edges(300);
    pin_in = 1'b1;
    edges(935);
    chk("R4 restart after inactive sample", tamper_flag, 0);
    edges(1);
    chk("R4 event on 4th consecutive sample", tamper_flag, 1);

    // R4 8 samples, low level active
    reset_cfg();
    pin_in = 1'b0; cfg_polarity = 1'b0; cfg_filter = 2'd3; cfg_ts_en = 1'b1;
    edges(4);
    expect_ts(5);
    cfg_enable = 1'b1;
    edges(2047);
    chk("R4 low level before 8th sample", tamper_flag, 0);
    edges(1);
    chk("R4 low level on 8th sample", tamper_flag, 1);
    edges(600);
    chk("R9 capture pulses all seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule